// File: doc/BRIEF.md
# LED Blink Generator with Auto-Stop

This block drives a single LED with a programmable on/off pattern. A free-running prescaler produces timing ticks whose spacing is selected as a power-of-two fraction of a long base interval. A 12-bit period counter advances on each tick, and the LED is lit while that counter is below a 12-bit duty value. Software sets the pattern through four registers on a simple synchronous write / combinational read bus.

Auto-stop is optional. When it is enabled, every completed period decrements a 16-bit stop count. When the count runs out, the generator shuts itself off and raises an interrupt unless the interrupt is masked. The control logic is a two-state machine:

- **ST_IDLE**: the counters are held at zero and the LED is dark.
- **ST_RUN**: the generator blinks.

The transitions are:

- **ST_IDLE → ST_RUN** (start): a time-base write with the run bit set.
- **ST_RUN → ST_IDLE** (software stop): a time-base write with the run bit clear.
- **ST_RUN → ST_IDLE** (expiry): the final auto-stop period completes with no time-base write in the same cycle.
- A time-base write with the run bit set while in ST_RUN keeps the block in ST_RUN.

Top module: `led_blinker`

## Requirements
- R1: After reset `led_o` and `irq_o` are 0, the block is in ST_IDLE, and all four registers read 0.
- R2: Registers are decoded by `addr[3:2]`; `addr[1:0]` is ignored. The layout is:
  - 0x00 time base: bits 3:0 select n, bit 4 is run (reads back the state, 1 = ST_RUN), bit 5 enables auto-stop, bit 6 masks the interrupt.
  - 0x04 period, 12 bits.
  - 0x08 duty, 12 bits.
  - 0x0C stop count, 16 bits.
  - Bits above each field read 0.
- R3: While running, a tick occurs once every 2^(14-n) clocks, with n read from bits 3:0 of the time-base register. Any n above 13 behaves as 13.
- R4: The period counter runs from 0 to period-1 and advances one step per tick. A period value of 0 behaves as 1.
- R5: `led_o` is 1 exactly while running with the period counter below duty. It follows that duty ≥ period keeps the LED on continuously and duty 0 keeps it off.
- R6: A write to the period or duty register restarts both the prescaler and the period counter at zero, in the same cycle as the write.
- R7: With auto-stop enabled, each completed period decrements the stop count while the count is non-zero. The period that completes with a count of 1 or 0 clears run, which darkens the LED, sets the count to 0 and sets the interrupt pending flag.
- R8: `irq_o` equals the pending flag gated by NOT mask. Any time-base write clears the pending flag.
- R9: A time-base write with run = 0 darkens the LED from the next cycle on. With auto-stop disabled the stop count never changes except by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| led_o | output | 1 | LED drive |
| irq_o | output | 1 | Auto-stop interrupt |

## Verification
The assertions check the following on every cycle:
- Ticks are never adjacent.
- The period counter stays inside its period and returns to zero after each wrap.
- Expiry always lands in ST_IDLE with the interrupt pending.
- The stop count decrements by exactly one per auto-stop period and holds when auto-stop is off.
- A time-base write clears the pending flag.
- The LED is dark whenever the block is stopped.

Only the bench scenarios can show the following:
- The exact tick spacing for each n, including the clamp above 13 and the longest base.
- The on/off shape of the waveform.
- The restart on period or duty writes.
- The cycle on which expiry occurs.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } blink_state_e;

    typedef enum logic [1:0] {
        RIX_TBASE  = 2'd0,
        RIX_PERIOD = 2'd1,
        RIX_DUTY   = 2'd2,
        RIX_STOP   = 2'd3
    } reg_ix_e;

    localparam int TB_SEL_W    = 4;
    localparam int TB_RUN_BIT  = 4;
    localparam int TB_AUTO_BIT = 5;
    localparam int TB_MASK_BIT = 6;

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int PRE_W   = 14,
    parameter int SEL_W   = 4,
    parameter int SEL_MAX = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] win_mask;
    logic [SEL_W-1:0] sel_eff;

    // clamp the divider select, then keep (PRE_W - n) low bits in the window
    always_comb begin
        sel_eff  = (sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel;
        win_mask = {PRE_W{1'b1}} >> sel_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run || restart)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    always_comb tick = run && !restart && ((pre_q & win_mask) == win_mask);

    // window is at least two clocks wide, so ticks never touch
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/led_wave.sv
module led_wave #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             led,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             at_last;

    always_comb begin
        last    = (period == '0) ? '0 : period - 1'b1;
        at_last = (cnt_q >= last);
        wrap    = tick && at_last;
        led     = run && (cnt_q < duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/led_ctrl.sv
module led_ctrl
    import led_blink_pkg::*;
#(
    parameter int STOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_wr,
    input  logic              tb_run,
    input  logic              stop_wr,
    input  logic [STOP_W-1:0] stop_wdata,
    input  logic              auto_en,
    input  logic              wrap,
    output logic              running,
    output logic [STOP_W-1:0] stop_cnt,
    output logic              irq_pend
);
    blink_state_e      state_q, state_d;
    logic [STOP_W-1:0] stop_cnt_q;
    logic              pend_q;
    logic              expire;

    always_comb expire = (state_q == ST_RUN) && auto_en && wrap &&
                         (stop_cnt_q <= STOP_W'(1));

    // next-state logic: software write outranks expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tb_wr && tb_run) state_d = ST_RUN;
            ST_RUN: begin
                if (tb_wr)       state_d = tb_run ? ST_RUN : ST_IDLE;
                else if (expire) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running  = (state_q == ST_RUN);
        stop_cnt = stop_cnt_q;
        irq_pend = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stop_cnt_q <= '0;
        else if (stop_wr)
            stop_cnt_q <= stop_wdata;
        else if (running && auto_en && wrap && stop_cnt_q != '0)
            stop_cnt_q <= stop_cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (tb_wr)  pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
    end

    p_expire_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !tb_wr) |=> (state_q == ST_IDLE && pend_q));

    p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && auto_en && wrap && !stop_wr && stop_cnt_q > STOP_W'(1))
        |=> (stop_cnt_q == $past(stop_cnt_q) - 1'b1));

    p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tb_wr |=> !pend_q);

    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !stop_wr) |=> (stop_cnt_q == $past(stop_cnt_q)));

endmodule

// File: rtl/led_blinker.sv
module led_blinker
    import led_blink_pkg::*;
#(
    parameter int PRE_W   = 14,
    parameter int SEL_MAX = 13,
    parameter int CNT_W   = 12,
    parameter int STOP_W  = 16,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              led_o,
    output logic              irq_o
);
    localparam int SEL_W = TB_SEL_W;

    reg_ix_e           ix;
    logic              tb_wr, per_wr, duty_wr, stop_wr, restart;
    logic [SEL_W-1:0]  sel_q;
    logic              auto_q, mask_q;
    logic [CNT_W-1:0]  period_q, duty_q;
    logic              running, tick, wrap, led_w, irq_pend;
    logic [STOP_W-1:0] stop_cnt;

    always_comb begin
        ix      = reg_ix_e'(addr[3:2]);
        tb_wr   = wr_en && (ix == RIX_TBASE);
        per_wr  = wr_en && (ix == RIX_PERIOD);
        duty_wr = wr_en && (ix == RIX_DUTY);
        stop_wr = wr_en && (ix == RIX_STOP);
        restart = per_wr || duty_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            auto_q   <= 1'b0;
            mask_q   <= 1'b0;
            period_q <= '0;
            duty_q   <= '0;
        end else begin
            if (tb_wr) begin
                sel_q  <= wdata[SEL_W-1:0];
                auto_q <= wdata[TB_AUTO_BIT];
                mask_q <= wdata[TB_MASK_BIT];
            end
            if (per_wr)  period_q <= wdata[CNT_W-1:0];
            if (duty_wr) duty_q   <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (ix)
            RIX_TBASE: begin
                rdata[SEL_W-1:0]   = sel_q;
                rdata[TB_RUN_BIT]  = running;
                rdata[TB_AUTO_BIT] = auto_q;
                rdata[TB_MASK_BIT] = mask_q;
            end
            RIX_PERIOD: rdata[CNT_W-1:0]  = period_q;
            RIX_DUTY:   rdata[CNT_W-1:0]  = duty_q;
            RIX_STOP:   rdata[STOP_W-1:0] = stop_cnt;
        endcase
    end

    led_tick_gen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(restart),
        .sel(sel_q), .tick(tick)
    );

    led_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(restart),
        .tick(tick), .period(period_q), .duty(duty_q),
        .led(led_w), .wrap(wrap)
    );

    led_ctrl #(.STOP_W(STOP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tb_wr(tb_wr), .tb_run(wdata[TB_RUN_BIT]),
        .stop_wr(stop_wr), .stop_wdata(wdata[STOP_W-1:0]), .auto_en(auto_q),
        .wrap(wrap), .running(running), .stop_cnt(stop_cnt), .irq_pend(irq_pend)
    );

    always_comb begin
        led_o = led_w;
        irq_o = irq_pend && !mask_q;
    end

    p_dark_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !led_o);

endmodule

// File: tb/led_blinker_test.sv
module led_blinker_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        led_o, irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    led_blinker uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .led_o(led_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ends at the falling edge right after the write edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic exp_led(int j, int L, int P, int D, int stop_at);
        int pe;
        if (stop_at > 0 && j >= stop_at) return 1'b0;
        pe = (P == 0) ? 1 : P;
        return ((j / L) % pe) < D;
    endfunction

    // compares led_o with the model on every falling edge, j = 0 first
    task automatic window(input string tag, input int L, input int P, input int D,
                          input int stop_at, input int n);
        int nbad = 0;
        for (int j = 0; j < n; j++) begin
            logic e;
            e = exp_led(j, L, P, D, stop_at);
            if (led_o !== e) begin
                if (nbad == 0)
                    $display("FAIL %s led at j=%0d actual=%0b expected=%0b", tag, j, led_o, e);
                nbad++;
            end
            @(negedge clk);
        end
        total++;
        if (nbad != 0) bad++;
    endtask

    task automatic stop_all();
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 led after reset", led_o, 0);
        chk("R1 irq after reset", irq_o, 0);
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), d);
            chk("R1 register reads zero", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(4'h4, 16'hFFFF);
        rd(4'h4, d); chk("R2 period 12-bit field", d, 16'h0FFF);
        rd(4'h7, d); chk("R2 addr[1:0] ignored", d, 16'h0FFF);
        wr(4'h8, 16'hA5A5);
        rd(4'h8, d); chk("R2 duty 12-bit field", d, 16'h05A5);
        wr(4'hC, 16'hBEEF);
        rd(4'hC, d); chk("R2 stop count 16-bit", d, 16'hBEEF);
        wr(4'h0, 16'hFF4F);
        rd(4'h0, d); chk("R2 time base fields, run clear", d, 16'h004F);
        stop_all();
    endtask

    task automatic t_basic();
        wr(4'h4, 16'd5); wr(4'h8, 16'd2);
        wr(4'h0, 16'h001D);
        window("R3 R4 R5 n=13 P=5 D=2", 2, 5, 2, 0, 40);
        stop_all();
    endtask

    task automatic t_n12();
        wr(4'h4, 16'd3); wr(4'h8, 16'd1);
        wr(4'h0, 16'h001C);
        window("R3 n=12 P=3 D=1", 4, 3, 1, 0, 48);
        stop_all();
    endtask

    task automatic t_clamp();
        wr(4'h4, 16'd4); wr(4'h8, 16'd3);
        wr(4'h0, 16'h001F);
        window("R3 n=15 clamps to 13", 2, 4, 3, 0, 32);
        stop_all();
    endtask

    task automatic t_duty_edges();
        wr(4'h4, 16'd3); wr(4'h8, 16'd7);
        wr(4'h0, 16'h001D);
        window("R5 duty above period stays on", 2, 3, 7, 0, 24);
        stop_all();
        wr(4'h8, 16'd0);
        wr(4'h0, 16'h001D);
        window("R5 duty zero stays off", 2, 3, 0, 0, 24);
        stop_all();
        wr(4'h4, 16'd0); wr(4'h8, 16'd1);
        wr(4'h0, 16'h001D);
        window("R4 period zero acts as one", 2, 0, 1, 0, 16);
        stop_all();
    endtask

    task automatic t_longest();
        wr(4'h4, 16'd2); wr(4'h8, 16'd1);
        wr(4'h0, 16'h0010);
        window("R3 n=0 longest base", 16384, 2, 1, 0, 2 * 16384 + 8);
        stop_all();
    endtask

    task automatic t_restart();
        wr(4'h4, 16'd4); wr(4'h8, 16'd2);
        wr(4'h0, 16'h001D);
        repeat (5) @(negedge clk);
        wr(4'h8, 16'd3);
        window("R6 duty write restarts", 2, 4, 3, 0, 32);
        repeat (3) @(negedge clk);
        wr(4'h4, 16'd5);
        window("R6 period write restarts", 2, 5, 3, 0, 30);
        stop_all();
    endtask

    task automatic t_autostop();
        logic [15:0] d;
        int nbad = 0;
        wr(4'h4, 16'd3); wr(4'h8, 16'd1); wr(4'hC, 16'd3);
        wr(4'h0, 16'h003D);
        for (int j = 0; j < 26; j++) begin
            logic e;
            e = exp_led(j, 2, 3, 1, 18);
            if (led_o !== e) begin
                if (nbad == 0)
                    $display("FAIL R7 led at j=%0d actual=%0b expected=%0b", j, led_o, e);
                nbad++;
            end
            if (j == 7) begin
                rd(4'hC, d); chk("R7 count after one period", d, 16'd2);
                chk("R8 no irq before expiry", irq_o, 0);
            end
            @(negedge clk);
        end
        total++;
        if (nbad != 0) bad++;
        chk("R8 irq after expiry", irq_o, 1);
        rd(4'hC, d); chk("R7 count zero at expiry", d, 16'd0);
        rd(4'h0, d); chk("R7 run cleared by expiry", d, 16'h002D);
        wr(4'h0, 16'h002D);
        chk("R8 time base write clears irq", irq_o, 0);
    endtask

    task automatic t_masked();
        logic [15:0] d;
        wr(4'h4, 16'd2); wr(4'h8, 16'd1); wr(4'hC, 16'd1);
        wr(4'h0, 16'h007D);
        window("R7 single-period auto-stop", 2, 2, 1, 4, 10);
        chk("R8 masked irq stays low", irq_o, 0);
        rd(4'h0, d); chk("R7 run cleared, masked", d, 16'h006D);
        stop_all();
    endtask

    task automatic t_sw_stop();
        logic [15:0] d;
        wr(4'h4, 16'd2); wr(4'h8, 16'd2); wr(4'hC, 16'd5);
        wr(4'h0, 16'h001D);
        repeat (10) @(negedge clk);
        chk("R5 on while running", led_o, 1);
        wr(4'h0, 16'h000D);
        chk("R9 dark right after stop", led_o, 0);
        repeat (10) @(negedge clk);
        chk("R9 still dark", led_o, 0);
        rd(4'hC, d); chk("R9 count untouched without auto-stop", d, 16'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_n12();
        t_clamp();
        t_duty_edges();
        t_longest();
        t_restart();
        t_autostop();
        t_masked();
        t_sw_stop();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule